// File: doc/BRIEF.md
# Configuration Image Size Extractor

This block parses the opening bytes of a configuration flash (already bit-reversed into normal byte order) as they stream past. It works out how many bytes the stored configuration image occupies. It takes one byte in each cycle that `in_valid` is high. It skips the erased-flash padding, locks onto the header sync code and steps over the field that follows it. It then collects a little-endian bit count and converts it to a byte count, rounding up.

A `start` pulse arms the parser. Once a verdict is reached, `result_valid` rises and holds until the next `start`. `result_size` then carries the image size, or zero when no usable header was found. Any bytes that arrive after the verdict have no effect. The window length, the length of the skipped field, the width of the count and both code values are parameters.

Top module: `cfgsz_extract`

## Requirements
- R1: After reset, `result_valid` is 0 and `result_size` is 0.
- R2: On a cycle with `start` high, all scan state is cleared and scanning begins at window position 0. A byte offered in that same cycle is ignored. `result_valid` is 0 on the cycle after `start`.
- R3: While the parser is looking for the header, a byte equal to the padding code (default 0xFF) is skipped.
- R4: A byte equal to the sync code (default 0x6A) starts the header. The next SKIP_BYTES accepted bytes (default 4) are skipped, whatever their values, including 0x6A and 0xFF. The COUNT_BYTES bytes after those (default 4) form the bit count, least significant byte first.
- R5: `result_size` equals (bit count + 7) >> 3, computed without overflow. The output is COUNT_BYTES*8-2 bits wide, so a count of 0xFFFFFFFF gives 0x20000000, a count of 1 gives 1, and a count of 0 gives 0.
- R6: While the parser is looking for the header, any byte other than the padding or sync code ends the scan: `result_valid` goes to 1 and `result_size` is 0.
- R7: A sync code is accepted only at window positions 0 to WINDOW_BYTES-9 (0 to 119 by default). This guarantees that the header fits in the window. If every position from 0 to WINDOW_BYTES-9 holds padding, the scan ends after that last position with `result_valid` 1 and `result_size` 0.
- R8: `result_valid` rises on the clock edge that accepts the deciding byte: the last count byte, the bad byte, or the last allowed padding byte. Both outputs then hold steady until the next `start`.
- R9: Cycles with `in_valid` low do not advance the scan. Bytes offered before the first `start` have no effect. Bytes offered after the verdict have no effect.
- R10: While a scan is in progress, `result_valid` is 0 and `result_size` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears state and arms a new scan |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Next byte from the start of the flash |
| result_valid | output | 1 | A verdict is held on `result_size` |
| result_size | output | COUNT_BYTES*8-2 (30) | Image size in bytes; 0 means unknown |

## Verification
The bench uses the default parameters: a 128-byte window, a 4-byte skipped field and a 4-byte count. With these, the whole window is visited in every stream, and the last legal sync position (119) and the first illegal one (120) can both be driven directly. The 30-bit output lets an all-ones count show that the rounding does not wrap. Random padding lengths with idle gaps place the header at every region of the window. A reference function predicts both the deciding byte and the size.

// File: rtl/cfgsz_pkg.sv
package cfgsz_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SCAN  = 3'd1,
      ST_SKIP  = 3'd2,
      ST_COUNT = 3'd3,
      ST_DONE  = 3'd4
   } scan_state_t;

   function automatic int width_of(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/cfgsz_scan_fsm.sv
module cfgsz_scan_fsm
   import cfgsz_pkg::*;
#(
   parameter int            WINDOW_BYTES = 128,
   parameter int            SKIP_BYTES   = 4,
   parameter int            COUNT_BYTES  = 4,
   parameter logic [7:0]    SYNC_CODE    = 8'h6A,
   parameter logic [7:0]    PAD_CODE     = 8'hFF,
   localparam int           LANE_W       = width_of(COUNT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   output scan_state_t       state_o,
   output logic              lane_we,
   output logic [LANE_W-1:0] lane_idx,
   output logic              found_o
);

   localparam int LAST_SYNC = WINDOW_BYTES - 1 - SKIP_BYTES - COUNT_BYTES;
   localparam int POS_W     = width_of(WINDOW_BYTES);
   localparam int FLD_MAX   = (SKIP_BYTES > COUNT_BYTES) ? SKIP_BYTES : COUNT_BYTES;
   localparam int FLD_W     = width_of(FLD_MAX);
   localparam logic [POS_W-1:0] LAST_POS   = POS_W'(LAST_SYNC);
   localparam logic [FLD_W-1:0] SKIP_LAST  = FLD_W'(SKIP_BYTES - 1);
   localparam logic [FLD_W-1:0] COUNT_LAST = FLD_W'(COUNT_BYTES - 1);

   if (SKIP_BYTES < 1) begin : g_bad_skip
      $error("cfgsz_scan_fsm: SKIP_BYTES must be at least 1");
   end
   if (COUNT_BYTES < 1) begin : g_bad_count
      $error("cfgsz_scan_fsm: COUNT_BYTES must be at least 1");
   end
   if (LAST_SYNC < 0) begin : g_bad_window
      $error("cfgsz_scan_fsm: window too short for one header");
   end

   scan_state_t      state_q;
   logic [POS_W-1:0] pos_q;
   logic [FLD_W-1:0] fld_q;
   logic             found_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pos_q   <= '0;
         fld_q   <= '0;
         found_q <= 1'b0;
      end else if (start) begin
         state_q <= ST_SCAN;
         pos_q   <= '0;
         fld_q   <= '0;
         found_q <= 1'b0;
      end else if (in_valid) begin
         unique case (state_q)
            ST_SCAN: begin
               if (in_byte == PAD_CODE) begin
                  if (pos_q == LAST_POS) state_q <= ST_DONE;
                  else                   pos_q   <= pos_q + 1'b1;
               end else if (in_byte == SYNC_CODE) begin
                  state_q <= ST_SKIP;
                  fld_q   <= '0;
               end else begin
                  state_q <= ST_DONE;
               end
            end
            ST_SKIP: begin
               if (fld_q == SKIP_LAST) begin
                  state_q <= ST_COUNT;
                  fld_q   <= '0;
               end else begin
                  fld_q <= fld_q + 1'b1;
               end
            end
            ST_COUNT: begin
               if (fld_q == COUNT_LAST) begin
                  state_q <= ST_DONE;
                  found_q <= 1'b1;
               end else begin
                  fld_q <= fld_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign state_o  = state_q;
   assign found_o  = found_q;
   assign lane_we  = in_valid && !start && (state_q == ST_COUNT);
   assign lane_idx = fld_q[LANE_W-1:0];

endmodule

// File: rtl/cfgsz_count_asm.sv
module cfgsz_count_asm
   import cfgsz_pkg::*;
#(
   parameter int  COUNT_BYTES = 4,
   localparam int LANE_W      = width_of(COUNT_BYTES),
   localparam int COUNT_W     = COUNT_BYTES * BYTE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               lane_we,
   input  logic [LANE_W-1:0]  lane_idx,
   input  logic [BYTE_W-1:0]  lane_byte,
   output logic [COUNT_W-1:0] count_o
);

   for (genvar k = 0; k < COUNT_BYTES; k++) begin : g_lane
      logic [BYTE_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    byte_q <= '0;
         else if (clear)                                byte_q <= '0;
         else if (lane_we && lane_idx == LANE_W'(k))    byte_q <= lane_byte;
      end
      assign count_o[k*BYTE_W +: BYTE_W] = byte_q;
   end

endmodule

// File: rtl/cfgsz_round.sv
module cfgsz_round #(
   parameter int  COUNT_W = 32,
   localparam int SIZE_W  = COUNT_W - 2
) (
   input  logic [COUNT_W-1:0] bits_i,
   output logic [SIZE_W-1:0]  bytes_o
);

   if (COUNT_W < 4) begin : g_bad_w
      $error("cfgsz_round: COUNT_W must be at least 4");
   end

   logic partial;
   assign partial = |bits_i[2:0];
   assign bytes_o = SIZE_W'(bits_i[COUNT_W-1:3]) + SIZE_W'(partial);

endmodule

// File: rtl/cfgsz_extract.sv
module cfgsz_extract
   import cfgsz_pkg::*;
#(
   parameter int         WINDOW_BYTES = 128,
   parameter int         SKIP_BYTES   = 4,
   parameter int         COUNT_BYTES  = 4,
   parameter logic [7:0] SYNC_CODE    = 8'h6A,
   parameter logic [7:0] PAD_CODE     = 8'hFF,
   localparam int        COUNT_W      = COUNT_BYTES * BYTE_W,
   localparam int        SIZE_W       = COUNT_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   output logic              result_valid,
   output logic [SIZE_W-1:0] result_size
);

   localparam int LANE_W = width_of(COUNT_BYTES);

   scan_state_t        state;
   logic               lane_we;
   logic [LANE_W-1:0]  lane_idx;
   logic               found;
   logic [COUNT_W-1:0] bit_count;
   logic [SIZE_W-1:0]  byte_count;

   cfgsz_scan_fsm #(
      .WINDOW_BYTES (WINDOW_BYTES),
      .SKIP_BYTES   (SKIP_BYTES),
      .COUNT_BYTES  (COUNT_BYTES),
      .SYNC_CODE    (SYNC_CODE),
      .PAD_CODE     (PAD_CODE)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .state_o  (state),
      .lane_we  (lane_we),
      .lane_idx (lane_idx),
      .found_o  (found)
   );

   cfgsz_count_asm #(
      .COUNT_BYTES (COUNT_BYTES)
   ) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start),
      .lane_we   (lane_we),
      .lane_idx  (lane_idx),
      .lane_byte (in_byte),
      .count_o   (bit_count)
   );

   cfgsz_round #(
      .COUNT_W (COUNT_W)
   ) u_round (
      .bits_i  (bit_count),
      .bytes_o (byte_count)
   );

   assign result_valid = (state == ST_DONE);
   assign result_size  = found ? byte_count : '0;

endmodule

// File: rtl/cfgsz_extract_chk.sv
module cfgsz_extract_chk #(
   parameter int WINDOW_BYTES = 128,
   parameter int SIZE_W       = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              in_valid,
   input logic              result_valid,
   input logic [SIZE_W-1:0] result_size
);

   localparam int CW = $clog2(WINDOW_BYTES + 2) + 1;
   localparam logic [CW-1:0] CMAX = '1;

   logic [CW-1:0] taken_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         taken_q <= '0;
      else if (start)                     taken_q <= '0;
      else if (in_valid && taken_q != CMAX) taken_q <= taken_q + 1'b1;
   end

   assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !result_valid);

   assert_size_zero_scanning_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> result_size == '0);

   assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && !start) |=> (result_valid && $stable(result_size)));

   assert_decided_by_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(result_valid) |-> $past(in_valid));

   assert_within_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(result_valid) |-> taken_q <= CW'(WINDOW_BYTES));

endmodule

bind cfgsz_extract cfgsz_extract_chk #(
   .WINDOW_BYTES (WINDOW_BYTES),
   .SIZE_W       (SIZE_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .in_valid     (in_valid),
   .result_valid (result_valid),
   .result_size  (result_size)
);

// File: tb/cfgsz_extract_test.sv
`timescale 1ns/1ps
module cfgsz_extract_test;

   localparam int WIN  = 128;
   localparam int LAST = WIN - 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        result_valid;
   logic [29:0] result_size;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [7:0] stream [0:WIN-1];

   always #2 clk = ~clk;

   cfgsz_extract uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .in_valid     (in_valid),
      .in_byte      (in_byte),
      .result_valid (result_valid),
      .result_size  (result_size)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // reference: returns deciding byte index and expected size
   task automatic model(output int sz, output int dec);
      logic [31:0] cnt;
      logic [32:0] t;
      sz = 0;
      dec = LAST;
      for (int i = 0; i <= LAST; i++) begin
         if (stream[i] == 8'h6A) begin
            cnt = {stream[i+8], stream[i+7], stream[i+6], stream[i+5]};
            t = {1'b0, cnt} + 33'd7;
            sz = int'(t >> 3);
            dec = i + 8;
            return;
         end else if (stream[i] != 8'hFF) begin
            dec = i;
            return;
         end
      end
   endtask

   task automatic fill(input logic [7:0] v);
      for (int i = 0; i < WIN; i++) stream[i] = v;
   endtask

   task automatic put_header(input int pos, input logic [31:0] fld, input logic [31:0] cnt);
      for (int i = 0; i < pos; i++) stream[i] = 8'hFF;
      stream[pos] = 8'h6A;
      for (int j = 0; j < 4; j++) begin
         stream[pos+1+j] = fld[8*j +: 8];
         stream[pos+5+j] = cnt[8*j +: 8];
      end
   endtask

   task automatic do_start(input logic v, input logic [7:0] b);
      start = 1'b1; in_valid = v; in_byte = b;
      @(negedge clk);
      start = 1'b0; in_valid = 1'b0;
      chk("R2 valid low after start", result_valid, 0);
      chk("R2 size zero after start", result_size, 0);
   endtask

   task automatic feed(input int n, input bit gaps, input string tag);
      int sz, dec;
      model(sz, dec);
      for (int k = 0; k < n; k++) begin
         if (gaps && $urandom_range(0, 3) == 0) begin
            in_valid = 1'b0; in_byte = 8'($urandom);
            @(negedge clk);
            chk("R9 idle cycle", result_valid, (k - 1 >= dec));
         end
         in_valid = 1'b1; in_byte = stream[k];
         @(negedge clk);
         in_valid = 1'b0;
         chk("R8 verdict timing", result_valid, (k >= dec));
         if (k >= dec) chk(tag, result_size, 64'(sz));
         else          chk("R10 size zero while scanning", result_size, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R1 reset valid", result_valid, 0);
      chk("R1 reset size", result_size, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: bytes before any start
      for (int i = 0; i < 12; i++) begin
         in_valid = 1'b1; in_byte = (i == 0) ? 8'h12 : 8'h6A;
         @(negedge clk);
      end
      in_valid = 1'b0;
      chk("R9 pre-start bytes ignored", result_valid, 0);

      // R3 R4 R5: padding then header
      do_start(1'b0, 8'h00);
      fill(8'h55); put_header(10, 32'h0, 32'h0000_1000);
      feed(WIN, 1'b0, "R3 R4 size 0x200");
      chk("R5 size 0x200", result_size, 64'h200);
      for (int i = 0; i < 4; i++) begin
         in_valid = 1'b1; in_byte = 8'h12; @(negedge clk);
      end
      in_valid = 1'b0;
      chk("R9 post-verdict valid", result_valid, 1);
      chk("R9 post-verdict size", result_size, 64'h200);

      // R5 rounding corners
      do_start(1'b0, 8'h00); fill(8'h00); put_header(0, 32'h0, 32'd1);
      feed(16, 1'b0, "R5 count 1");
      do_start(1'b0, 8'h00); fill(8'h00); put_header(3, 32'h0, 32'hFFFF_FFFF);
      feed(16, 1'b0, "R5 count all ones");
      chk("R5 no wrap", result_size, 64'h2000_0000);
      do_start(1'b0, 8'h00); fill(8'h00); put_header(1, 32'h0, 32'd0);
      feed(16, 1'b0, "R5 count 0");
      do_start(1'b0, 8'h00); fill(8'h00); put_header(2, 32'h0, 32'd9);
      feed(16, 1'b1, "R5 count 9");

      // R6 bad bytes
      do_start(1'b0, 8'h00); fill(8'hFF); stream[5] = 8'h12;
      feed(20, 1'b0, "R6 bad byte at 5");
      do_start(1'b0, 8'h00); fill(8'hFF); stream[0] = 8'h00;
      feed(4, 1'b0, "R6 bad byte at 0");

      // R7 window limits
      do_start(1'b0, 8'h00); fill(8'hFF);
      feed(WIN, 1'b1, "R7 all padding");
      do_start(1'b0, 8'h00); fill(8'hFF); put_header(LAST, 32'h0, 32'h0000_0100);
      feed(WIN, 1'b0, "R7 sync at last slot");
      chk("R7 last slot size", result_size, 64'h20);
      do_start(1'b0, 8'h00); fill(8'hFF); put_header(LAST + 1, 32'h0, 32'h0000_0100);
      feed(WIN, 1'b0, "R7 sync past last slot");
      chk("R7 past slot size", result_size, 0);

      // R4 skipped field holds codes
      do_start(1'b0, 8'h00); fill(8'h00); put_header(4, 32'h6A6A_FF12, 32'h20);
      feed(20, 1'b0, "R4 field ignored");
      chk("R4 field ignored size", result_size, 64'h4);

      // R2 restart mid-scan, byte on start cycle ignored
      do_start(1'b0, 8'h00); fill(8'h00); put_header(2, 32'h0, 32'h40);
      feed(5, 1'b0, "R2 partial");
      do_start(1'b1, 8'h12);
      fill(8'h00); put_header(6, 32'h0, 32'h80);
      feed(20, 1'b0, "R2 restart");
      chk("R2 restart size", result_size, 64'h10);

      // random streams
      for (int n = 0; n < 40; n++) begin
         int p, kind;
         for (int i = 0; i < WIN; i++) stream[i] = 8'($urandom);
         p = $urandom_range(0, 125);
         for (int i = 0; i < p; i++) stream[i] = 8'hFF;
         kind = $urandom_range(0, 9);
         if (kind < 8) stream[p] = 8'h6A;
         else if (kind == 8) begin
            logic [7:0] g;
            g = 8'($urandom);
            while (g == 8'hFF || g == 8'h6A) g = 8'($urandom);
            stream[p] = g;
         end else begin
            for (int i = p; i < WIN; i++) stream[i] = 8'hFF;
         end
         do_start(1'b0, 8'h00);
         feed(WIN, 1'b1, "R4 R5 random stream");
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule